// File: doc/BRIEF.md
# Serial Frame Checksum Gate

This block sits between the serial input of a register interface and the logic that writes the registers. Bits arrive one per accepted beat while the active-low frame select is held low. The block shifts them in and counts them. When frame select rises it closes the frame and judges it by length alone. A 24-bit frame is forwarded as a write word without any check. A 32-bit frame carries 24 data bits followed by an 8-bit checksum. It is forwarded only if that checksum matches the one the block computed over the data. Frames of any other length are dropped without a trace.

A failed check discards the word and sets a sticky error flag. An active-low error pin mirrors the flag. The flag stays set until the register-interface logic pulses `err_clr`, which it does when software reads back the control register. The write word leaves on a valid/ready channel. While a word waits for `wr_ready`, `bit_ready` is low, so the serial source stalls and no following frame can overrun it. A frame whose bits were all refused in this way closes with a length of 0 and is dropped.

Top module: `spi_crc_gate`

## Requirements
- R1: After reset `wr_valid` is 0, `err_flag` is 0, `err_n` is 1 and `bit_ready` is 1.
- R2: A frame of exactly 24 accepted bits is forwarded without any check. In the cycle after frame select rises, `wr_valid` is 1 and `wr_data` holds the bits with the first bit received in bit 23.
- R3: A frame of exactly 32 accepted bits is forwarded when its last 8 bits equal the CRC-8 of its first 24 bits. The CRC uses polynomial x^8+x^2+x+1 (0x07), starts at 0x00, has no final XOR and takes the data MSB first. `wr_data` then holds the first 24 bits.
- R4: A 32-bit frame whose checksum does not match produces no write. In the cycle after frame select rises, `err_flag` is 1 and `err_n` is 0.
- R5: A frame of any length other than 24 or 32 bits, including 0, produces no write and leaves `err_flag` unchanged.
- R6: A pulse on `err_clr` with no failing frame in the same cycle brings `err_flag` to 0 and `err_n` to 1 in the next cycle.
- R7: If a failing frame closes in the same cycle as an `err_clr` pulse, the flag ends up set.
- R8: While the flag is set, further good frames, ignored frames and failing frames leave it set.
- R9: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid` stays 1, `wr_data` is stable and `bit_ready` is 0. The word is taken on a cycle with both high.
- R10: A bit beat presented while frame select is high is not counted and does not change the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sel_n | input | 1 | Active-low frame select; a rising edge closes the frame |
| bit_vld | input | 1 | Serial bit beat valid |
| bit_in | input | 1 | Serial data bit, MSB first |
| bit_ready | output | 1 | Bit beat accepted when high together with bit_vld |
| wr_valid | output | 1 | Write word valid |
| wr_ready | input | 1 | Write word consumed when high together with wr_valid |
| wr_data | output | 24 | Write word |
| err_clr | input | 1 | Clear pulse for the error flag (control register read) |
| err_flag | output | 1 | Sticky checksum error flag |
| err_n | output | 1 | Active-low checksum error output |

## Verification
Two events can land on the same clock edge: the close of a frame that fails its checksum, and a clear pulse from a control register read. The bench first sets the flag. It then raises frame select on a failing frame and drives `err_clr` in the same cycle, and expects the flag still set one cycle later. A plain clear with no frame closing is run next to that case as the contrast, and it must drop the flag. A second overlap, a write word held against a stalled `wr_ready` while the next frame tries to send bits, is judged by `bit_ready` staying low and the held word staying unchanged.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int DATA_W = 24;
  localparam int CRC_W  = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
  localparam int FRAME_W = DATA_W + CRC_W;
  localparam int CNT_SAT = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_SAT + 1);

  typedef enum logic [1:0] {
    FR_IGNORE = 2'd0,
    FR_PLAIN  = 2'd1,
    FR_CHECK  = 2'd2
  } frame_kind_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                 input logic din);
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/frm_shift.sv
module frm_shift
  import frm_pkg::*;
#(
  parameter int W  = FRAME_W,
  parameter int CW = CNT_W,
  parameter int SAT = CNT_SAT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          din,
  input  logic          restart,
  output logic [W-1:0]  sreg,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      count <= '0;
    end else if (restart) begin
      count <= '0;
    end else if (take) begin
      sreg <= {sreg[W-2:0], din};
      if (count != CW'(SAT)) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/frm_crc.sv
module frm_crc
  import frm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             din,
  input  logic [CW-1:0]    count,
  input  logic             restart,
  output logic [CRC_W-1:0] crc
);
  logic in_data;
  assign in_data = (count < CW'(DW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= '0;
    else if (restart) crc <= '0;
    else if (take && in_data) crc <= crc_step(crc, din);
  end
endmodule

// File: rtl/frm_judge.sv
module frm_judge
  import frm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int FW = FRAME_W,
  parameter int CW = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close,
  input  logic [CW-1:0]    count,
  input  logic [FW-1:0]    sreg,
  input  logic [CRC_W-1:0] crc,
  input  logic             err_clr,
  input  logic             wr_ready,
  output logic             wr_valid,
  output logic [DW-1:0]    wr_data,
  output logic             err_flag,
  output logic             chk_fail
);
  frame_kind_e kind;
  logic        pass;
  logic [DW-1:0] word;

  always_comb begin
    kind = FR_IGNORE;
    word = sreg[DW-1:0];
    if (count == CW'(DW)) begin
      kind = FR_PLAIN;
    end else if (count == CW'(FW)) begin
      kind = FR_CHECK;
      word = sreg[FW-1:CRC_W];
    end
  end

  assign pass     = close && ((kind == FR_PLAIN) ||
                    ((kind == FR_CHECK) && (sreg[CRC_W-1:0] == crc)));
  assign chk_fail = close && (kind == FR_CHECK) && (sreg[CRC_W-1:0] != crc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else if (pass) begin
      wr_valid <= 1'b1;
      wr_data  <= word;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_flag <= 1'b0;
    else if (chk_fail) err_flag <= 1'b1;
    else if (err_clr)  err_flag <= 1'b0;
  end
endmodule

// File: rtl/spi_crc_gate.sv
module spi_crc_gate
  import frm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int FW = FRAME_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_sel_n,
  input  logic          bit_vld,
  input  logic          bit_in,
  output logic          bit_ready,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [DW-1:0] wr_data,
  input  logic          err_clr,
  output logic          err_flag,
  output logic          err_n
);
  logic             sel_q;
  logic             close;
  logic             take;
  logic [FW-1:0]    sreg;
  logic [CW-1:0]    count;
  logic [CRC_W-1:0] crc;
  logic             chk_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b1;
    else        sel_q <= frame_sel_n;
  end

  assign close     = !sel_q && frame_sel_n;
  assign bit_ready = !wr_valid;
  assign take      = !frame_sel_n && bit_vld && bit_ready;

  frm_shift #(.W(FW), .CW(CW), .SAT(FW + 1)) u_shift (
    .clk(clk), .rst_n(rst_n), .take(take), .din(bit_in),
    .restart(close), .sreg(sreg), .count(count)
  );

  frm_crc #(.DW(DW), .CW(CW)) u_crc (
    .clk(clk), .rst_n(rst_n), .take(take), .din(bit_in),
    .count(count), .restart(close), .crc(crc)
  );

  frm_judge #(.DW(DW), .FW(FW), .CW(CW)) u_judge (
    .clk(clk), .rst_n(rst_n), .close(close), .count(count),
    .sreg(sreg), .crc(crc), .err_clr(err_clr), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .err_flag(err_flag),
    .chk_fail(chk_fail)
  );

  assign err_n = !err_flag;
endmodule

// File: rtl/spi_crc_gate_chk.sv
module spi_crc_gate_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          close,
  input logic          chk_fail,
  input logic          err_clr,
  input logic          err_flag,
  input logic          err_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          bit_ready,
  input logic [DW-1:0] wr_data
);
  a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

  a_r9_stall_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> !bit_ready);

  a_r4_fail_sets: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fail |=> (err_flag && !err_n));

  a_r4_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fail && !wr_valid) |=> !wr_valid);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !chk_fail) |=> !err_flag);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  a_r5_rise_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(close));
endmodule

bind spi_crc_gate spi_crc_gate_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .close(close), .chk_fail(chk_fail),
  .err_clr(err_clr), .err_flag(err_flag), .err_n(err_n),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .bit_ready(bit_ready),
  .wr_data(wr_data)
);

// File: tb/sim_spi_crc_gate.sv
`timescale 1ns/1ps
module sim_spi_crc_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sel_n = 1'b1;
  logic        bit_vld = 1'b0;
  logic        bit_in = 1'b0;
  logic        bit_ready;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [23:0] wr_data;
  logic        err_clr = 1'b0;
  logic        err_flag;
  logic        err_n;

  int total = 0;
  int bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  spi_crc_gate u0 (
    .clk(clk), .rst_n(rst_n), .frame_sel_n(frame_sel_n), .bit_vld(bit_vld),
    .bit_in(bit_in), .bit_ready(bit_ready), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .err_clr(err_clr),
    .err_flag(err_flag), .err_n(err_n)
  );

  function automatic logic [7:0] ref_crc(input logic [23:0] d);
    logic [31:0] v;
    v = {d, 8'h00};
    for (int i = 31; i >= 8; i--)
      if (v[i]) v = v ^ (32'h107 << (i - 8));
    return v[7:0];
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // send len bits of val, MSB of the len-bit field first; raise select on last negedge
  task automatic send_bits(input int len, input logic [39:0] val);
    @(negedge clk);
    frame_sel_n = 1'b0;
    for (int i = len - 1; i >= 0; i--) begin
      while (!bit_ready) @(negedge clk);
      bit_vld = 1'b1;
      bit_in  = val[i];
      @(negedge clk);
    end
    bit_vld = 1'b0;
  endtask

  // raise select; returns at the negedge after the close edge
  task automatic close_frame(input logic clr);
    frame_sel_n = 1'b1;
    err_clr = clr;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic pulse_clear();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] d;
    logic [7:0]  c;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 err_flag", err_flag, 0);
    chk("R1 err_n", err_n, 1);
    chk("R1 bit_ready", bit_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 plain 24-bit frames
    for (int k = 0; k < 24; k++) begin
      seed = nxt(seed);
      d = (k < 24) ? (24'h1 << k) ^ seed[23:0] : 24'h0;
      send_bits(24, {16'h0, d});
      close_frame(1'b0);
      chk("R2 wr_valid", wr_valid, 1);
      chk("R2 wr_data", wr_data, d);
      @(negedge clk);
      chk("R2 one beat", wr_valid, 0);
    end
    chk("R2 no error", err_flag, 0);

    // R3 good checked frames
    for (int k = 0; k < 40; k++) begin
      seed = nxt(seed);
      d = (k == 0) ? 24'h0 : (k == 1) ? 24'hFFFFFF : seed[31:8];
      send_bits(32, {8'h0, d, ref_crc(d)});
      close_frame(1'b0);
      chk("R3 wr_valid", wr_valid, 1);
      chk("R3 wr_data", wr_data, d);
      chk("R3 no error", err_flag, 0);
      @(negedge clk);
    end

    // R5 other lengths ignored
    for (int len = 0; len <= 36; len++) begin
      if (len == 24 || len == 32) continue;
      seed = nxt(seed);
      send_bits(len, {seed[7:0], seed});
      close_frame(1'b0);
      chk("R5 no write", wr_valid, 0);
      chk("R5 flag clear", err_flag, 0);
    end

    // R10 beats while select high are not counted
    @(negedge clk);
    bit_vld = 1'b1; bit_in = 1'b1;
    repeat (5) @(negedge clk);
    bit_vld = 1'b0;
    d = 24'hA5_3C_96;
    send_bits(24, {16'h0, d});
    close_frame(1'b0);
    chk("R10 wr_valid", wr_valid, 1);
    chk("R10 wr_data", wr_data, d);
    @(negedge clk);

    // R4 bad checksum: flip each checksum bit, clear between
    for (int b = 0; b < 8; b++) begin
      seed = nxt(seed);
      d = seed[23:0];
      c = ref_crc(d) ^ (8'h1 << b);
      send_bits(32, {8'h0, d, c});
      close_frame(1'b0);
      chk("R4 no write", wr_valid, 0);
      chk("R4 err_flag", err_flag, 1);
      chk("R4 err_n", err_n, 0);
      pulse_clear();
      chk("R6 cleared", err_flag, 0);
      chk("R6 err_n", err_n, 1);
    end
    // R4 data bit corrupted
    d = 24'h00F00D;
    send_bits(32, {8'h0, d ^ 24'h000100, ref_crc(d)});
    close_frame(1'b0);
    chk("R4 data flip no write", wr_valid, 0);
    chk("R4 data flip flag", err_flag, 1);

    // R8 sticky across good, ignored and failing frames
    d = 24'h123456;
    send_bits(32, {8'h0, d, ref_crc(d)});
    close_frame(1'b0);
    chk("R8 good writes", wr_valid, 1);
    chk("R8 flag held after good", err_flag, 1);
    @(negedge clk);
    send_bits(10, 40'h3FF);
    close_frame(1'b0);
    chk("R8 flag held after ignored", err_flag, 1);
    send_bits(32, {8'h0, d, ~ref_crc(d)});
    close_frame(1'b0);
    chk("R8 flag held after fail", err_flag, 1);

    // R7 clear and failing close together: error wins
    send_bits(32, {8'h0, d, ~ref_crc(d)});
    close_frame(1'b1);
    chk("R7 fail beats clear", err_flag, 1);
    chk("R7 err_n", err_n, 0);
    // R7 same from a clear flag
    pulse_clear();
    chk("R6 plain clear", err_flag, 0);
    send_bits(32, {8'h0, d, ref_crc(d) ^ 8'h80});
    close_frame(1'b1);
    chk("R7 set despite clear", err_flag, 1);
    pulse_clear();
    // R5 ignored frame with clear flag leaves it clear, with set flag leaves it set
    send_bits(31, 40'h7FFF_FFFF);
    close_frame(1'b0);
    chk("R5 ignored keeps clear", err_flag, 0);

    // R9 back-pressure
    wr_ready = 1'b0;
    d = 24'hBEEF01;
    send_bits(24, {16'h0, d});
    close_frame(1'b0);
    for (int k = 0; k < 6; k++) begin
      chk("R9 held valid", wr_valid, 1);
      chk("R9 held data", wr_data, d);
      chk("R9 bit_ready low", bit_ready, 0);
      @(negedge clk);
    end
    // frame closing while stalled has no accepted bits: dropped
    frame_sel_n = 1'b0; bit_vld = 1'b1; bit_in = 1'b0;
    repeat (24) @(negedge clk);
    bit_vld = 1'b0;
    close_frame(1'b0);
    chk("R9 word unchanged", wr_data, d);
    chk("R9 still valid", wr_valid, 1);
    wr_ready = 1'b1;
    @(negedge clk);
    chk("R9 taken", wr_valid, 0);
    chk("R9 bit_ready back", bit_ready, 1);
    d = 24'h0BCDEF;
    send_bits(24, {16'h0, d});
    close_frame(1'b0);
    chk("R9 next word", wr_data, d);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule